// File: doc/BRIEF.md
# Header-Steered Burst Capture Engine

This block receives words from an upstream receiver that presents a data bus with a one-cycle strobe per word. The first strobed word of a frame is held as a header. The words that follow form a payload of fixed length. Every payload word is written into one of two on-chip memories, and one bit of the header chooses the memory. The block writes each word at an address equal to its position in the payload. When the last payload word has been written, the block raises a one-cycle completion pulse and goes back to waiting for the next header.

The block accepts a strobe on every cycle. A write happens in the same cycle as its strobe, and the cycle that carries the completion pulse already accepts a new header. Each memory also has its own read port with registered output, so the stored payload can be read back.

Top module: `hdr_route_capture`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to the header-wait state. After that edge `busy` is 0, `done` is 0 and `hdr_word` is 0.
- R2: While waiting for a header, cycles without `rx_valid` change nothing. The first cycle with `rx_valid` stores `rx_data` into `hdr_word`, sets the word position to 0 and makes `busy` 1 from the next cycle.
- R3: While `busy` is 1, `hdr_word` holds its value, and cycles without `rx_valid` neither write nor advance the word position.
- R4: Header bit 0 selects the memory: 1 sends payload words to memory A, and 0 sends them to memory B. The memory not selected keeps its previous contents.
- R5: Payload word k (k counted from 0) is written at address k of the selected memory.
- R6: A frame holds exactly 100 payload words. After the edge that takes the 100th word, `busy` is 0.
- R7: `done` is 1 for exactly the one cycle that follows the edge taking the 100th payload word, and is 0 at every other time.
- R8: Strobes on consecutive cycles are all accepted. A strobe in the cycle where `done` is 1 is taken as the next header.
- R9: Each read port returns the word at its address one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | One-cycle strobe marking a received word |
| rx_data | input | 8 | Received word |
| busy | output | 1 | High while a payload is being collected |
| done | output | 1 | One-cycle pulse after the last payload word |
| hdr_word | output | 8 | Header captured for the current or last frame |
| rd_addr_a | input | 7 | Read address, memory A |
| rd_data_a | output | 8 | Registered read data, memory A |
| rd_addr_b | input | 7 | Read address, memory B |
| rd_data_b | output | 8 | Registered read data, memory B |

## Verification
The hardest case to reach is the boundary between frames under full load. Here the 100th payload word and the next header arrive on consecutive cycles, the header lands in the single cycle that carries the completion pulse, and the new header selects the other memory. The stimulus reaches this case by sending a payload with a strobe on every cycle and following it at once with a header strobe. It also runs frames with irregular gaps and a reset in the middle of a frame. Afterwards the bench reads back both memories in full and compares them with its own model, which shows that no word went to the wrong memory and no word was lost.

// File: rtl/hdr_route_capture_pkg.sv
package hdr_route_capture_pkg;

  typedef enum logic [0:0] {
    ST_WAIT_HDR  = 1'b0,
    ST_WAIT_WORD = 1'b1
  } cap_state_e;

  // Header bit SEL high routes to memory A (bank index 0).
  function automatic logic f_route_first(input logic [31:0] hdr, input int sel);
    return hdr[sel];
  endfunction

  // True when the word at position pos is the last of a burst of len words.
  function automatic logic f_is_last(input int unsigned pos, input int unsigned len);
    return (pos == len - 1);
  endfunction

endpackage

// File: rtl/hdr_route_capture_ctrl.sv
module hdr_route_capture_ctrl
  import hdr_route_capture_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 100,
  parameter int SEL_BIT   = 0,
  parameter int ADDR_W    = 7,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] hdr_q,
  output logic              wr_en,
  output logic              wr_to_first,
  output logic [ADDR_W-1:0] wr_addr
);

  cap_state_e       state_q, state_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [DATA_W-1:0] hdr_d;
  logic             done_d;
  logic             last_word;

  assign wr_en       = (state_q == ST_WAIT_WORD) && rx_valid;
  assign last_word   = f_is_last(32'(pos_q), BURST_LEN);
  assign wr_to_first = f_route_first(32'(hdr_q), SEL_BIT);
  assign wr_addr     = ADDR_W'(pos_q);
  assign busy        = (state_q == ST_WAIT_WORD);

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    hdr_d   = hdr_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_WAIT_HDR: begin
        if (rx_valid) begin
          hdr_d   = rx_data;
          pos_d   = '0;
          state_d = ST_WAIT_WORD;
        end
      end
      ST_WAIT_WORD: begin
        if (rx_valid) begin
          pos_d = pos_q + CNT_W'(1);
          if (last_word) begin
            state_d = ST_WAIT_HDR;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_WAIT_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT_HDR;
      pos_q   <= '0;
      hdr_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      hdr_q   <= hdr_d;
      done    <= done_d;
    end
  end

endmodule

// File: rtl/hdr_route_capture_bank.sv
module hdr_route_capture_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/hdr_route_capture.sv
module hdr_route_capture #(
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 100,
  parameter int MEM_DEPTH = 128,
  parameter int SEL_BIT   = 0,
  localparam int ADDR_W   = $clog2(MEM_DEPTH),
  localparam int N_BANKS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] hdr_word,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);

  logic              wr_en;
  logic              wr_to_first;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_first;
  logic              wr_second;

  logic [ADDR_W-1:0] bank_raddr [N_BANKS];
  logic [DATA_W-1:0] bank_rdata [N_BANKS];
  logic              bank_we    [N_BANKS];

  hdr_route_capture_ctrl #(
    .DATA_W   (DATA_W),
    .BURST_LEN(BURST_LEN),
    .SEL_BIT  (SEL_BIT),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .busy       (busy),
    .done       (done),
    .hdr_q      (hdr_word),
    .wr_en      (wr_en),
    .wr_to_first(wr_to_first),
    .wr_addr    (wr_addr)
  );

  assign wr_first  = wr_en && wr_to_first;
  assign wr_second = wr_en && !wr_to_first;

  assign bank_we[0]    = wr_first;
  assign bank_we[1]    = wr_second;
  assign bank_raddr[0] = rd_addr_a;
  assign bank_raddr[1] = rd_addr_b;
  assign rd_data_a     = bank_rdata[0];
  assign rd_data_b     = bank_rdata[1];

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    hdr_route_capture_bank #(
      .DATA_W(DATA_W),
      .DEPTH (MEM_DEPTH)
    ) u_bank (
      .clk  (clk),
      .we   (bank_we[g]),
      .waddr(wr_addr),
      .wdata(rx_data),
      .raddr(bank_raddr[g]),
      .rdata(bank_rdata[g])
    );
  end

endmodule

// File: rtl/hdr_route_capture_chk.sv
module hdr_route_capture_chk #(
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 100,
  parameter int ADDR_W    = 7,
  parameter int SEL_BIT   = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] hdr_word,
  input logic              wr_first,
  input logic              wr_second,
  input logic [ADDR_W-1:0] wr_addr
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done && hdr_word == '0));

  p_hdr_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && rx_valid) |=> (busy && hdr_word == $past(rx_data)));

  p_idle_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(wr_first || wr_second));

  p_hdr_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(hdr_word));

  p_one_bank_r4: assert property (@(posedge clk) disable iff (rst)
    $countones({wr_first, wr_second}) <= 1);

  p_bank_sel_r4: assert property (@(posedge clk) disable iff (rst)
    wr_first |-> hdr_word[SEL_BIT]);

  p_addr_range_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_first || wr_second) |-> (int'(wr_addr) < BURST_LEN));

  p_done_ends_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_strobe_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && rx_valid) |-> (wr_first || wr_second));

endmodule

bind hdr_route_capture hdr_route_capture_chk #(
  .DATA_W   (DATA_W),
  .BURST_LEN(BURST_LEN),
  .ADDR_W   (ADDR_W),
  .SEL_BIT  (SEL_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_valid (rx_valid),
  .rx_data  (rx_data),
  .busy     (busy),
  .done     (done),
  .hdr_word (hdr_word),
  .wr_first (wr_first),
  .wr_second(wr_second),
  .wr_addr  (wr_addr)
);

// File: tb/hdr_route_capture_tb.sv
module hdr_route_capture_tb;

  localparam int LEN = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       busy, done;
  logic [7:0] hdr_word;
  logic [6:0] rd_addr_a = '0, rd_addr_b = '0;
  logic [7:0] rd_data_a, rd_data_b;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  hdr_route_capture u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .busy(busy), .done(done), .hdr_word(hdr_word),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
  );

  always #2 clk = ~clk;

  // Behavioural reference model
  bit         m_busy, m_done, started;
  logic [7:0] m_hdr;
  int         m_pos;
  logic [7:0] ref_a [128];
  logic [7:0] ref_b [128];

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      m_busy = 0; m_done = 0; m_hdr = '0; m_pos = 0;
    end else begin
      m_done = 0;
      if (rx_valid) begin
        if (!m_busy) begin
          m_hdr = rx_data; m_pos = 0; m_busy = 1;
        end else begin
          if (m_hdr[0]) ref_a[m_pos] = rx_data;
          else          ref_b[m_pos] = rx_data;
          m_pos++;
          if (m_pos == LEN) begin m_busy = 0; m_done = 1; end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(busy === m_busy, "R2/R6 busy", busy, m_busy);
      chk(done === m_done, "R7 done", done, m_done);
      chk(hdr_word === m_hdr, "R3 hdr_word", hdr_word, m_hdr);
    end
  end

  task automatic strobe(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b0; rx_data = 8'hA5;
    end
  endtask

  // payload with optional gaps between words
  task automatic payload(input int seed, input int gap_mod);
    for (int i = 0; i < LEN; i++) begin
      strobe(8'((i * 7 + seed) & 8'hFF));
      if (gap_mod != 0 && (i % gap_mod) == 1) quiet(1 + (i % 3));
    end
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < LEN; a++) begin
      @(negedge clk); rx_valid = 1'b0; rd_addr_a = 7'(a); rd_addr_b = 7'(LEN - 1 - a);
      @(negedge clk);
      chk(rd_data_a === ref_a[a], {tag, " R5/R9 mem A"}, rd_data_a, ref_a[a]);
      chk(rd_data_b === ref_b[LEN-1-a], {tag, " R4/R5 mem B"}, rd_data_b, ref_b[LEN-1-a]);
    end
  endtask

  initial begin
    // R1 reset
    quiet(3);
    chk(busy === 1'b0 && done === 1'b0 && hdr_word === 8'h00, "R1 reset state", {busy, done}, 0);
    @(negedge clk); rst = 1'b0;
    quiet(4);
    chk(busy === 1'b0, "R2 idle without strobe", busy, 0);

    // frame to memory A, gapped words
    strobe(8'h01);
    quiet(1);
    chk(busy === 1'b1 && hdr_word === 8'h01, "R2 header captured", hdr_word, 8'h01);
    payload(3, 4);
    quiet(1);
    chk(busy === 1'b0, "R6 idle after 100 words", busy, 0);

    // frame to memory B, back-to-back, next header in done cycle
    strobe(8'hFE);
    payload(40, 0);
    strobe(8'h81);
    chk(done === 1'b1, "R7 done with header strobe", done, 1);
    @(negedge clk); rx_valid = 1'b0;
    chk(busy === 1'b1 && hdr_word === 8'h81, "R8 header in done cycle", hdr_word, 8'h81);
    payload(90, 0);
    quiet(2);
    read_all("pass1");

    // frame with header bit 0 clear only: A must stay as is (R4)
    strobe(8'h00);
    payload(200, 5);
    quiet(2);
    read_all("pass2");

    // reset in mid-frame
    strobe(8'h33);
    payload(11, 0);
    strobe(8'h44);
    strobe(8'h45);
    strobe(8'h46);
    @(negedge clk); rx_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(busy === 1'b0 && hdr_word === 8'h00, "R1 reset mid-frame", hdr_word, 0);
    strobe(8'h07);
    payload(5, 0);
    quiet(2);
    read_all("pass3");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule